// File: doc/BRIEF.md
# Bus Voltage Loop Controller

This block is the digital outer voltage loop of a boost power-factor preconverter. Each time the front-end converter presents a new bus-voltage error sample, the block runs it through a second-order notch. The notch removes the ripple at twice the line frequency that rides on the rectified bus. The result then goes to a proportional-integral regulator. The regulator output is a switch on-time command, counted in clock cycles, for the pulse sequencer that drives the power switch.

A mode input selects the fast-response path used while the lamp is igniting and during pre-run. In that mode the raw error code goes straight to the regulator and the notch is skipped. The notch keeps tracking its input in the background, and its history is wiped whenever the mode input changes. This prevents a stale filter state from producing a step in the command.

All state advances on a single sample-valid strobe. The command register and its valid flag change on the clock edge that samples the strobe.

Top module: `bus_loop_ctrl`

## Requirements
- R1: While `rst` is high, and right after it falls, `ton_cmd` equals TON_MIN (63) and `cmd_vld` is 0. The integrator holds TON_MIN·16.
- R2: `cmd_vld` is high for exactly the one cycle after a cycle with `smp_vld` high. `ton_cmd` changes only on that edge.
- R3: `err_code` is an 8-bit two's complement value in which a positive code means the bus is below its reference. A positive error raises the command. For example, from reset in bypass mode a single code of +40 gives 88 cycles.
- R4: In normal mode the notch output is y[n] = (16384·x[n] + B1·x[n-1] + 16384·x[n-2] − A1·y[n-1] − A2·y[n-2]) >>> 14, using a floor shift. The default coefficients are B1 = −31738, A1 = −28565 and A2 = 13271, which place the zero at 100 Hz for a 2.5 kHz sample rate.
- R5: The notch output saturates to the signed range of NOTCH_W bits, and the saturated value is the one stored as history.
- R6: When `bypass` is 1, the sign-extended error code replaces the notch output at the regulator input.
- R7: A cycle in which `bypass` differs from its value in the previous cycle zeroes all notch history. A strobe in that same cycle is filtered with zero history.
- R8: The integrator adds KI·e on each sample and is clamped to [TON_MIN·16, TON_MAX·16]. After a long stretch at saturation, one sample of the opposite sign moves the command off the limit at once.
- R9: `ton_cmd` = clamp((integrator + KP·e) >>> 4, TON_MIN, TON_MAX), which by default is 63 to 2875 cycles (0.5 µs to 23 µs at 125 MHz).
- R10: Setting MAINS_120 = 1 selects B1 = −31290, A1 = −28161 and A2 = 13271, which place the zero at 120 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | New error sample strobe |
| err_code | input | ERR_W | Signed bus-voltage error code |
| bypass | input | 1 | 1 = ignition/pre-run mode, notch skipped |
| ton_cmd | output | TON_W | On-time command in clock cycles |
| cmd_vld | output | 1 | Pulses one cycle after each strobe |

## Verification
The bench instantiates the block twice and feeds both instances the same stimulus. One instance uses the defaults: a 100 Hz notch with 12-bit output. The other uses MAINS_120 = 1 with an 8-bit notch output. With an 8-bit output, alternating full-scale codes exceed the notch's high-frequency gain, so the saturation path and its stored history can be exercised. This is not possible with the 12-bit default. With the default on-time limits, the bypass path can drive the integrator to either clamp within a couple of hundred samples, so anti-windup recovery is exercised from both ends.

// File: rtl/bus_loop_pkg.sv
package bus_loop_pkg;
  localparam int COEF_FRAC = 14;
  localparam int COEF_ONE  = 16384;
  localparam int INT_FRAC  = 4;

  localparam int B1_100 = -31738;
  localparam int A1_100 = -28565;
  localparam int B1_120 = -31290;
  localparam int A1_120 = -28161;
  localparam int A2_ALL = 13271;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction
endpackage

// File: rtl/bus_loop_notch.sv
module bus_loop_notch
  import bus_loop_pkg::*;
#(
  parameter int XW        = 8,
  parameter int YW        = 12,
  parameter bit MAINS_120 = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic                 clr,
  input  logic signed [XW-1:0] x,
  output logic signed [YW-1:0] y
);
  localparam int B1   = MAINS_120 ? B1_120 : B1_100;
  localparam int A1   = MAINS_120 ? A1_120 : A1_100;
  localparam int A2   = A2_ALL;
  localparam int YMAX = (2 ** (YW - 1)) - 1;
  localparam int YMIN = -(2 ** (YW - 1));

  logic signed [XW-1:0] x1_q, x2_q, x1_e, x2_e;
  logic signed [YW-1:0] y1_q, y2_q, y1_e, y2_e;
  int acc;

  // history seen by the current sample: zero on a mode-change cycle
  always_comb begin
    x1_e = clr ? '0 : x1_q;
    x2_e = clr ? '0 : x2_q;
    y1_e = clr ? '0 : y1_q;
    y2_e = clr ? '0 : y2_q;
    acc  = COEF_ONE * int'(x) + B1 * int'(x1_e) + COEF_ONE * int'(x2_e)
         - A1 * int'(y1_e) - A2 * int'(y2_e);
    y    = YW'(clamp_int(acc >>> COEF_FRAC, YMIN, YMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (smp_vld) begin
      x1_q <= x;
      x2_q <= x1_e;
      y1_q <= y;
      y2_q <= y1_e;
    end else if (clr) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end
  end
endmodule

// File: rtl/bus_loop_pi.sv
module bus_loop_pi
  import bus_loop_pkg::*;
#(
  parameter int EW      = 12,
  parameter int TON_W   = 12,
  parameter int TON_MIN = 63,
  parameter int TON_MAX = 2875,
  parameter int KP      = 8,
  parameter int KI      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [EW-1:0] e,
  output logic [TON_W-1:0]     ton_cmd,
  output logic                 cmd_vld
);
  localparam int ILO = TON_MIN <<< INT_FRAC;
  localparam int IHI = TON_MAX <<< INT_FRAC;

  int integ_q, integ_n, out_n;

  always_comb begin
    integ_n = clamp_int(integ_q + KI * int'(e), ILO, IHI);
    out_n   = clamp_int((integ_n + KP * int'(e)) >>> INT_FRAC, TON_MIN, TON_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= ILO;
      ton_cmd <= TON_W'(TON_MIN);
      cmd_vld <= 1'b0;
    end else begin
      cmd_vld <= smp_vld;
      if (smp_vld) begin
        integ_q <= integ_n;
        ton_cmd <= TON_W'(out_n);
      end
    end
  end
endmodule

// File: rtl/bus_loop_ctrl.sv
module bus_loop_ctrl #(
  parameter int ERR_W     = 8,
  parameter int NOTCH_W   = 12,
  parameter bit MAINS_120 = 1'b0,
  parameter int TON_W     = 12,
  parameter int TON_MIN   = 63,
  parameter int TON_MAX   = 2875,
  parameter int KP        = 8,
  parameter int KI        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [ERR_W-1:0] err_code,
  input  logic             bypass,
  output logic [TON_W-1:0] ton_cmd,
  output logic             cmd_vld
);
  logic                      mode_q;
  logic                      hist_clr;
  logic signed [NOTCH_W-1:0] filt;
  logic signed [NOTCH_W-1:0] pi_in;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= bypass;
  end

  assign hist_clr = bypass ^ mode_q;
  assign pi_in    = bypass ? NOTCH_W'($signed(err_code)) : filt;

  bus_loop_notch #(
    .XW(ERR_W), .YW(NOTCH_W), .MAINS_120(MAINS_120)
  ) u_notch (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .clr(hist_clr),
    .x($signed(err_code)), .y(filt)
  );

  bus_loop_pi #(
    .EW(NOTCH_W), .TON_W(TON_W), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX),
    .KP(KP), .KI(KI)
  ) u_pi (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .e(pi_in),
    .ton_cmd(ton_cmd), .cmd_vld(cmd_vld)
  );
endmodule

// File: rtl/bus_loop_chk.sv
module bus_loop_chk #(
  parameter int TON_W   = 12,
  parameter int TON_MIN = 63,
  parameter int TON_MAX = 2875
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic [TON_W-1:0] ton_cmd,
  input logic             cmd_vld
);
  p_vld_follows_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> cmd_vld);

  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !cmd_vld);

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_vld) && !$past(rst)) |-> $stable(ton_cmd));

  p_cmd_range_r9: assert property (@(posedge clk) disable iff (rst)
    (32'(ton_cmd) >= TON_MIN) && (32'(ton_cmd) <= TON_MAX));
endmodule

bind bus_loop_ctrl bus_loop_chk #(
  .TON_W(TON_W), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX)
) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .ton_cmd(ton_cmd), .cmd_vld(cmd_vld)
);

// File: tb/bus_loop_ctrl_bench.sv
`timescale 1ns/1ps
module bus_loop_ctrl_bench;
  localparam int TMIN = 63;
  localparam int TMAX = 2875;

  logic clk = 1'b0, rst = 1'b1, vld = 1'b0, byp = 1'b0;
  logic [7:0] err = '0;
  logic [11:0] ton0, ton1;
  logic cv0, cv1;

  bus_loop_ctrl u_bus_loop_ctrl (
    .clk(clk), .rst(rst), .smp_vld(vld), .err_code(err), .bypass(byp),
    .ton_cmd(ton0), .cmd_vld(cv0));

  bus_loop_ctrl #(.NOTCH_W(8), .MAINS_120(1'b1)) u_bus_loop_ctrl_120 (
    .clk(clk), .rst(rst), .smp_vld(vld), .err_code(err), .bypass(byp),
    .ton_cmd(ton1), .cmd_vld(cv1));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model, one set of state per instance
  int cb1[2] = '{-31738, -31290};
  int ca1[2] = '{-28565, -28161};
  int ymx[2] = '{2047, 127};
  int mx1[2], mx2[2], my1[2], my2[2], mint[2], mcmd[2], mvld[2];
  int mmode;

  always @(posedge clk) begin
    int xi, h1, h2, g1, g2, acc, yv, ev, itg, o;
    bit clr;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
        mint[k] = TMIN * 16; mcmd[k] = TMIN; mvld[k] = 0;
      end
      mmode = 0;
    end else begin
      xi  = int'($signed(err));
      clr = (int'(byp) != mmode);
      for (int k = 0; k < 2; k++) begin
        h1 = clr ? 0 : mx1[k]; h2 = clr ? 0 : mx2[k];
        g1 = clr ? 0 : my1[k]; g2 = clr ? 0 : my2[k];
        acc = 16384 * xi + cb1[k] * h1 + 16384 * h2 - ca1[k] * g1 - 13271 * g2;
        yv  = acc >>> 14;
        if (yv > ymx[k]) yv = ymx[k];
        if (yv < -ymx[k] - 1) yv = -ymx[k] - 1;
        mvld[k] = vld;
        if (vld) begin
          ev  = byp ? xi : yv;
          itg = mint[k] + 2 * ev;
          if (itg < TMIN * 16) itg = TMIN * 16;
          if (itg > TMAX * 16) itg = TMAX * 16;
          mint[k] = itg;
          o = (itg + 8 * ev) >>> 4;
          if (o < TMIN) o = TMIN;
          if (o > TMAX) o = TMAX;
          mcmd[k] = o;
          mx1[k] = xi; mx2[k] = h1; my1[k] = yv; my2[k] = g1;
        end else begin
          mx1[k] = h1; mx2[k] = h2; my1[k] = g1; my2[k] = g2;
        end
      end
      mmode = int'(byp);
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({req, "/100Hz ton"}, int'(ton0), mcmd[0]);
      chk({req, "/R10 ton"},   int'(ton1), mcmd[1]);
      chk("R2 vld",  int'(cv0), mvld[0]);
      chk("R2 vld/R10", int'(cv1), mvld[1]);
    end
  end

  task automatic smp(int v);
    @(negedge clk); err = 8'(v); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(bit b);
    @(negedge clk); byp = b;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL R2 watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ton", int'(ton0), TMIN);
    chk("R1 vld", int'(cv0), 0);
    chk("R1 ton/R10", int'(ton1), TMIN);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 ton after release", int'(ton0), TMIN);

    req = "R3";
    set_mode(1'b1);
    smp(40);
    chk("R3 +40 raises", int'(ton0), 88);
    smp(-40);
    chk("R3 -40 lowers", int'(ton0), TMIN);

    req = "R6";
    for (int i = 0; i < 20; i++) smp((i * 37) % 200 - 100);

    req = "R4";
    set_mode(1'b0);
    for (int i = 0; i < 250; i++)
      smp($rtoi($floor(60.0 * $sin(6.2831853 * i / 25.0) + 0.5)));
    for (int i = 0; i < 30; i++) smp(25);

    req = "R5";
    for (int i = 0; i < 40; i++) smp((i % 2 == 0) ? 127 : -128);

    req = "R7";
    set_mode(1'b1);
    set_mode(1'b0);
    smp(0);
    smp(50);
    @(negedge clk); byp = 1'b1; err = 8'(-30); vld = 1'b1;
    @(negedge clk); vld = 1'b0; byp = 1'b0;
    smp(10);
    smp(-10);

    req = "R9";
    set_mode(1'b1);
    for (int i = 0; i < 200; i++) smp(127);
    chk("R9 upper clamp", int'(ton0), TMAX);
    req = "R8";
    smp(-1);
    chk("R8 leaves upper limit", int'(ton0), 2874);
    req = "R9";
    for (int i = 0; i < 200; i++) smp(-128);
    chk("R9 lower clamp", int'(ton0), TMIN);
    req = "R8";
    smp(8);
    chk("R8 leaves lower limit", int'(ton0), 68);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule